// File: doc/BRIEF.md
# Bus Master Latency Timer

This block bounds how long a local bus master may keep the bus once it has started a transaction. Software programs an 8-bit limit through a small write port. The limit is counted in bus clock cycles. When the master's state machine signals that it has asserted its frame, the block loads a down-counter from the limit and starts counting.

If the count reaches zero while the transaction is still open, the block raises a terminate request. The request does not stop the transfer at once. It tells the master to finish the transaction when the data phase now in flight completes. The request stays high until the master reports that phase as complete, and the transaction then closes. If the transaction ends on its own first, the counter stops and no request is raised.

The limit is read back combinationally from the stored register. A value of 20h or more lets typical transactions finish before the limit is reached. A value of zero allows exactly one further data phase after frame assertion. All pins are plain control strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_tenure_limiter`

## Requirements
- R1: After reset, `cfg_rd_data` reads 00h and `term_req` is low.
- R2: A write sampled with `cfg_wr_en` high shows all 8 bits of `cfg_wr_data` on `cfg_rd_data` from the next cycle on. With `cfg_wr_en` low, the stored value does not change.
- R3: With a limit L greater than 0, `term_req` is low for the first L-1 cycles after the clock edge that samples `frame_start`, and rises L cycles after that edge, provided the transaction has not ended.
- R4: With a limit of 0, `term_req` is high in the first cycle after the edge that samples `frame_start`.
- R5: Once high, `term_req` stays high until `phase_done` is sampled. It is low in the cycle after that. A `phase_done` sampled before expiry has no effect on the countdown.
- R6: A `xfer_done` sampled before expiry ends the transaction. `term_req` then stays low until a new `frame_start`.
- R7: A register write made while a transaction is open does not change that transaction's countdown. The next `frame_start` uses the new value.
- R8: A `frame_start` sampled while a transaction is open restarts the countdown from the register value.
- R9: When `frame_start` and `xfer_done` are sampled in the same cycle, `frame_start` wins and a new countdown starts.
- R10: When `frame_start` and a register write are sampled in the same cycle, the countdown uses the value held before the write. The write still updates `cfg_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. One count unit is one cycle of this clock. |
| rst_n | input | 1 | Active-low synchronous reset. |
| cfg_wr_en | input | 1 | Write strobe for the limit register. |
| cfg_wr_data | input | 8 | New limit value. |
| cfg_rd_data | output | 8 | Current limit value. |
| frame_start | input | 1 | One-cycle strobe: the master has asserted its frame. |
| phase_done | input | 1 | One-cycle strobe: a data phase has completed. |
| xfer_done | input | 1 | One-cycle strobe: the transaction has ended. |
| term_req | output | 1 | Request to end the transaction after the current data phase. |

## Verification
Each result has a fixed due time:
- `cfg_rd_data` changes one cycle after a write.
- `term_req` rises exactly L cycles after the edge that samples `frame_start`.
- `term_req` falls one cycle after the edge that samples `phase_done` or `xfer_done`.

The bench drives every strobe for exactly one cycle, starting at a falling edge, so the next rising edge samples it. It then counts falling edges and samples at each one. It checks that `term_req` is low at every count below L and high exactly at L. The same counting is used for the cycle after a terminating strobe and for the register read-back one cycle after a write.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  localparam int unsigned TENURE_W_DEF = 8;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } tenure_state_e;
endpackage

// File: rtl/tenure_cfg_reg.sv
module tenure_cfg_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)     q_r <= RST_VAL;
    else if (wr_en) q_r <= wr_data;
  end

  assign q = q_r;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data)); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R2
endmodule

// File: rtl/tenure_down_counter.sv
module tenure_down_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         cnt_zero
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign cnt_zero = (cnt_q == '0);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !cnt_zero) |=> cnt_q == $past(cnt_q) - ONE); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tenure_term_ctl.sv
module tenure_term_ctl
  import tenure_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic phase_done,
  input  logic xfer_done,
  input  logic cnt_zero,
  output logic load,
  output logic dec,
  output logic term_req
);
  tenure_state_e st_q, st_d;
  logic active;

  assign active   = (st_q == ST_ACTIVE);
  assign term_req = active && cnt_zero;
  assign load     = frame_start;
  assign dec      = active && !frame_start && !cnt_zero;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_start) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (frame_start)                  st_d = ST_ACTIVE;
        else if (xfer_done)               st_d = ST_IDLE;
        else if (term_req && phase_done)  st_d = ST_IDLE;
        else                              st_d = ST_ACTIVE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_TERM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (term_req && !phase_done && !xfer_done && !frame_start) |=> term_req); // R5
  AST_TERM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (term_req && phase_done && !frame_start) |=> !term_req); // R5
  AST_DONE_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !frame_start) |=> !term_req); // R6
  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> active); // R9
endmodule

// File: rtl/bus_tenure_limiter.sv
module bus_tenure_limiter
  import tenure_pkg::*;
#(
  parameter int unsigned TIMER_W = TENURE_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [TIMER_W-1:0] cfg_wr_data,
  output logic [TIMER_W-1:0] cfg_rd_data,
  input  logic               frame_start,
  input  logic               phase_done,
  input  logic               xfer_done,
  output logic               term_req
);
  logic [TIMER_W-1:0] limit_q;
  logic load, dec, cnt_zero;

  tenure_cfg_reg #(.W(TIMER_W), .RST_VAL('0)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .q       (limit_q)
  );

  tenure_down_counter #(.W(TIMER_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (limit_q),
    .dec      (dec),
    .cnt_zero (cnt_zero)
  );

  tenure_term_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .phase_done  (phase_done),
    .xfer_done   (xfer_done),
    .cnt_zero    (cnt_zero),
    .load        (load),
    .dec         (dec),
    .term_req    (term_req)
  );

  assign cfg_rd_data = limit_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!term_req && cfg_rd_data == '0)); // R1
  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && limit_q == '0) |=> term_req); // R4
endmodule

// File: tb/test_bus_tenure_limiter.sv
`timescale 1ns/1ps
module test_bus_tenure_limiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       frame_start = 1'b0;
  logic       phase_done = 1'b0;
  logic       xfer_done = 1'b0;
  logic       term_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bus_tenure_limiter #(.TIMER_W(8)) i_bus_tenure_limiter (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .frame_start(frame_start), .phase_done(phase_done), .xfer_done(xfer_done),
    .term_req(term_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // One-cycle strobe set: sampled by the next rising edge.
  task automatic drive(input logic f, input logic p, input logic x,
                       input logic we, input logic [7:0] wd);
    frame_start = f; phase_done = p; xfer_done = x;
    cfg_wr_en = we; cfg_wr_data = wd;
    step();
    frame_start = 0; phase_done = 0; xfer_done = 0; cfg_wr_en = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    drive(0, 0, 0, 1, v);
  endtask

  // Called right after the frame strobe was sampled: checks low up to L-1, high at L.
  task automatic expect_expiry(input string tag, input int lim);
    for (int k = 0; k < lim; k++) begin
      check(tag, term_req, 0);
      step();
    end
    check(tag, term_req, 1);
  endtask

  task automatic close_phase(input string tag);
    drive(0, 1, 0, 0, 8'h00);
    check(tag, term_req, 0);
  endtask

  task automatic t_reset();
    check("R1 rd", cfg_rd_data, 0);
    check("R1 term", term_req, 0);
  endtask

  task automatic t_write();
    wr(8'hA5); check("R2 A5", cfg_rd_data, 8'hA5);
    wr(8'h5A); check("R2 5A", cfg_rd_data, 8'h5A);
    step();    check("R2 hold", cfg_rd_data, 8'h5A);
  endtask

  task automatic t_expire();
    wr(8'd4);
    drive(1, 0, 0, 0, 0);
    expect_expiry("R3 L4", 4);
    for (int k = 0; k < 3; k++) begin step(); check("R5 hold", term_req, 1); end
    close_phase("R5 clear");
    step(); check("R5 stays low", term_req, 0);
  endtask

  task automatic t_early_phase();
    wr(8'd6);
    drive(1, 0, 0, 0, 0);
    step(); step();
    drive(0, 1, 0, 0, 0);
    expect_expiry("R5 early phase", 3);
    close_phase("R5 clear2");
  endtask

  task automatic t_zero();
    wr(8'd0);
    drive(1, 0, 0, 0, 0);
    check("R4 zero", term_req, 1);
    step(); check("R4 hold", term_req, 1);
    close_phase("R4 clear");
  endtask

  task automatic t_done_early();
    wr(8'd3);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    for (int k = 0; k < 10; k++) begin check("R6 quiet", term_req, 0); step(); end
  endtask

  task automatic t_write_during();
    wr(8'd5);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 8'd2);
    check("R7 rd", cfg_rd_data, 2);
    expect_expiry("R7 old", 4);
    close_phase("R7 clear");
    drive(1, 0, 0, 0, 0);
    expect_expiry("R7 new", 2);
    close_phase("R7 clear2");
  endtask

  task automatic t_restart();
    wr(8'd4);
    drive(1, 0, 0, 0, 0);
    step();
    drive(1, 0, 0, 0, 0);
    expect_expiry("R8 restart", 4);
    close_phase("R8 clear");
  endtask

  task automatic t_frame_done_same();
    wr(8'd3);
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0);
    expect_expiry("R9 frame wins", 3);
    close_phase("R9 clear");
  endtask

  task automatic t_frame_write_same();
    wr(8'd3);
    drive(1, 0, 0, 1, 8'd7);
    check("R10 rd", cfg_rd_data, 7);
    expect_expiry("R10 old value", 3);
    close_phase("R10 clear");
  endtask

  task automatic t_max();
    wr(8'hFF);
    drive(1, 0, 0, 0, 0);
    expect_expiry("R3 max", 255);
    close_phase("R3 max clear");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_write();
    t_expire();
    t_early_phase();
    t_zero();
    t_done_early();
    t_write_during();
    t_restart();
    t_frame_done_same();
    t_frame_write_same();
    t_max();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule